// File: doc/BRIEF.md
# Asynchronous 8/9-Bit Serial Port

This block is a full-duplex asynchronous serial port with one transmitter and one receiver. Software selects one of three framings with a two-bit mode input. One framing carries eight data bits at a variable rate. One carries nine bits at a fixed rate taken from the core clock. One carries nine bits at a variable rate. In the variable-rate framings the timing comes from two external pulses, one for transmit and one for receive. Each pulse marks one sixteenth of a bit period, so the two directions can run at different speeds. In the fixed-rate framing an internal divider sets the bit period to 64 core clocks, or to 32 when the rate-double input is high.

A write strobe loads a byte and a ninth bit into the transmitter. The frame leaves at the next bit boundary of the transmit timebase. The transmit-done flag rises in the same cycle that the stop bit first appears on the line.

The receiver synchronises the line with two flops and waits for a falling edge. It then takes three samples in the middle of each bit and uses their majority. A frame is accepted only when the receive-done flag is clear, the stop bit is high, and, with address filtering on in a 9-bit mode, the ninth bit is high. An accepted frame updates the received byte, the received ninth bit and the receive-done flag. A frame that fails any of these conditions is discarded and nothing visible changes. Both flags stay set until software clears them with a one-cycle strobe.

The transmitter is a state machine with the states TX_IDLE, TX_WAIT, TX_START, TX_DATA, TX_NINTH and TX_STOP:
- TX_IDLE goes to TX_WAIT on an accepted write.
- TX_WAIT goes to TX_START at the next bit boundary.
- TX_START goes to TX_DATA at the next bit boundary.
- TX_DATA goes, after the eighth bit, to TX_NINTH in a 9-bit framing or to TX_STOP in the 8-bit framing.
- TX_NINTH goes to TX_STOP at the next bit boundary.
- TX_STOP goes back to TX_IDLE after one bit period.

The receiver is a state machine with the states RX_IDLE, RX_START, RX_DATA, RX_NINTH and RX_STOP:
- RX_IDLE goes to RX_START on a falling edge while receive is enabled.
- RX_START goes back to RX_IDLE on a false start, or to RX_DATA at the end of the start bit.
- RX_DATA goes, after the eighth bit, to RX_NINTH or RX_STOP according to the framing.
- RX_NINTH goes to RX_STOP at the end of the ninth bit.
- RX_STOP goes back to RX_IDLE at the middle of the stop bit. The accept decision is made at that point.

Top module: `serial_port_core`

## Requirements
- R1: After reset the line output is 1, both flags are 0, and the received byte and received ninth bit are 0.
- R2: The mode input selects the framing. 01 gives a 10-bit frame: start 0, eight data bits LSB first, stop 1. 10 and 11 give an 11-bit frame: start 0, eight data bits LSB first, the ninth bit from tx_bit9, stop 1.
- R3: In mode 10 one bit lasts 64 clock cycles with rate_x2 at 0, and 32 clock cycles with rate_x2 at 1.
- R4: In modes 01 and 11 one transmit bit lasts 16 tx_tick pulses and one receive bit lasts 16 rx_tick pulses. The two tick inputs are independent.
- R5: A write starts a frame at the next transmit bit boundary. tx_done rises in the cycle the stop bit first drives the line. A write made while a frame is in progress is ignored.
- R6: A receive starts only on a falling edge of rxd while rx_enable is 1. With rx_enable at 0 a complete frame leaves all outputs unchanged.
- R7: Each received bit is the majority of the samples taken at oversample counts 7, 8 and 9 of 16. A glitch that corrupts only one of those samples does not change the bit.
- R8: A start bit that votes 1 at mid-bit is dropped as a false start, and no frame is received.
- R9: At the stop-bit decision a frame is accepted only if rx_done is 0 and the stop bit is 1. On acceptance rx_data takes the byte, rx_bit9 takes the ninth bit (or the stop bit in mode 01), and rx_done is set. Otherwise rx_data, rx_bit9 and rx_done keep their values.
- R10: With addr_filter at 1 in mode 10 or 11, a frame is accepted only if its ninth bit is 1. In mode 01, addr_filter has no effect.
- R11: A one-cycle tx_done_clr or rx_done_clr clears the matching flag. If the flag is set in the same cycle, the set wins.
- R12: Mode 00 disables both directions. Writes are ignored and incoming frames are not received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Framing select (00 off, 01 8-bit variable, 10 9-bit fixed, 11 9-bit variable) |
| rate_x2 | input | 1 | Halves the fixed-rate bit period |
| rx_enable | input | 1 | Allows new receptions to start |
| addr_filter | input | 1 | Accept only frames whose ninth bit is 1 (9-bit modes) |
| tx_tick | input | 1 | Transmit oversample pulse, 16 per bit, variable modes |
| rx_tick | input | 1 | Receive oversample pulse, 16 per bit, variable modes |
| tx_wr | input | 1 | One-cycle write strobe for the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit to transmit in 9-bit modes |
| tx_done_clr | input | 1 | Clears tx_done |
| rx_done_clr | input | 1 | Clears rx_done |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_done | output | 1 | Stop bit of the last frame has started |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit (or stop bit) of the last accepted frame |
| rx_done | output | 1 | A frame has been accepted |

## Verification
The bench checks the exact timing of tx_done against the middle of the last data bit and the middle of the stop bit. A flag set one bit early or one bit late fails one of the two samples. It sends frames whose only fault is a high rx_done, a low stop bit, a low ninth bit under address filtering, or a low rx_enable. A design that accepts any of these overwrites rx_data or raises rx_done. A two-clock glitch placed near mid-bit catches a receiver that trusts one sample. A short low pulse catches a receiver that has no false-start check and would take an all-ones byte. A second write during a frame, and a write in mode 00, catch a transmitter that restarts or runs when it should ignore the write.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

    localparam logic [1:0] MODE_OFF = 2'b00;
    localparam logic [1:0] MODE_8V  = 2'b01;
    localparam logic [1:0] MODE_9F  = 2'b10;
    localparam logic [1:0] MODE_9V  = 2'b11;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_WAIT,
        TX_START,
        TX_DATA,
        TX_NINTH,
        TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/sp_rate_sel.sv
module sp_rate_sel
    import serial_port_pkg::*;
#(
    parameter int FIXED_DIV = 64,
    parameter int OVS       = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       rate_x2,
    input  logic       tx_tick_ext,
    input  logic       rx_tick_ext,
    output logic       tx_tick,
    output logic       rx_tick
);
    localparam int STEP = FIXED_DIV / OVS;
    localparam int CW   = $clog2(STEP) + 1;
    localparam logic [CW-1:0] LIM_NORM = CW'(STEP - 1);
    localparam logic [CW-1:0] LIM_FAST = CW'(STEP / 2 - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          fix_tick;

    assign lim      = rate_x2 ? LIM_FAST : LIM_NORM;
    assign fix_tick = (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (fix_tick) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    always_comb begin
        unique case (mode)
            MODE_OFF: begin tx_tick = 1'b0;        rx_tick = 1'b0;        end
            MODE_9F:  begin tx_tick = fix_tick;    rx_tick = fix_tick;    end
            default:  begin tx_tick = tx_tick_ext; rx_tick = rx_tick_ext; end
        endcase
    end
endmodule

// File: rtl/sp_tx_fsm.sv
module sp_tx_fsm
    import serial_port_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          nine,
    input  logic          tick,
    input  logic          wr,
    input  logic [DW-1:0] data,
    input  logic          bit9,
    output logic          txd,
    output logic          stop_enter,
    output tx_state_t     state_o
);
    localparam int PW = $clog2(OVS);
    localparam int IW = $clog2(DW);

    tx_state_t     state, nxt;
    logic [PW-1:0] phase;
    logic [DW:0]   shreg;
    logic [IW-1:0] idx;
    logic          nine_q;
    logic          bnd;

    assign bnd = tick && (phase == PW'(OVS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (wr && enable) nxt = TX_WAIT;
            TX_WAIT:  if (bnd) nxt = TX_START;
            TX_START: if (bnd) nxt = TX_DATA;
            TX_DATA:  if (bnd && idx == IW'(DW - 1)) nxt = nine_q ? TX_NINTH : TX_STOP;
            TX_NINTH: if (bnd) nxt = TX_STOP;
            TX_STOP:  if (bnd) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= '0;
            shreg  <= '1;
            idx    <= '0;
            nine_q <= 1'b0;
        end else begin
            if (tick) phase <= phase + 1'b1;
            if (state == TX_IDLE && wr && enable) begin
                shreg  <= {bit9, data};
                idx    <= '0;
                nine_q <= nine;
            end else if (state == TX_DATA && bnd) begin
                shreg <= {1'b1, shreg[DW:1]};
                idx   <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_START:          txd = 1'b0;
            TX_DATA, TX_NINTH: txd = shreg[0];
            default:           txd = 1'b1;
        endcase
        stop_enter = (nxt == TX_STOP) && (state != TX_STOP);
        state_o    = state;
    end
endmodule

// File: rtl/sp_rx_fsm.sv
module sp_rx_fsm
    import serial_port_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          nine,
    input  logic          tick,
    input  logic          rxd_raw,
    input  logic          addr_filter,
    input  logic          busy,
    output logic          accept,
    output logic [DW-1:0] data_o,
    output logic          bit9_o,
    output rx_state_t     state_o
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] S_A  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] S_B  = CW'(OVS / 2);
    localparam logic [CW-1:0] S_C  = CW'(OVS / 2 + 1);
    localparam logic [CW-1:0] S_LS = CW'(OVS - 1);

    rx_state_t     state, nxt;
    logic          s1, s2, s3;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [DW-1:0] shreg;
    logic          va, vb, vote, b9_q, nine_q;
    logic          fall, mid, last;

    assign fall = s3 & ~s2;
    assign mid  = tick && (cnt == S_C);
    assign last = tick && (cnt == S_LS);
    assign vote = (va & vb) | (va & s2) | (vb & s2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (enable && fall) nxt = RX_START;
            RX_START: if (mid && vote) nxt = RX_IDLE;
                      else if (last) nxt = RX_DATA;
            RX_DATA:  if (last && idx == IW'(DW - 1)) nxt = nine_q ? RX_NINTH : RX_STOP;
            RX_NINTH: if (last) nxt = RX_STOP;
            RX_STOP:  if (mid) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_comb begin
        accept  = (state == RX_STOP) && mid && vote && !busy &&
                  (!(nine_q && addr_filter) || b9_q);
        state_o = state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
            cnt <= '0; idx <= '0; shreg <= '0;
            va <= 1'b1; vb <= 1'b1; b9_q <= 1'b0; nine_q <= 1'b0;
            data_o <= '0; bit9_o <= 1'b0;
        end else begin
            s1 <= rxd_raw;
            s2 <= s1;
            s3 <= s2;
            if (state == RX_IDLE) begin
                cnt <= '0;
                idx <= '0;
                if (fall) nine_q <= nine;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
                if (cnt == S_A) va <= s2;
                if (cnt == S_B) vb <= s2;
            end
            if (state == RX_DATA && mid)  shreg <= {vote, shreg[DW-1:1]};
            if (state == RX_DATA && last) idx <= idx + 1'b1;
            if (state == RX_NINTH && mid) b9_q <= vote;
            if (accept) begin
                data_o <= shreg;
                bit9_o <= nine_q ? b9_q : vote;
            end
        end
    end
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
    import serial_port_pkg::*;
#(
    parameter int FIXED_DIV = 64,
    parameter int OVS       = 16,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          rate_x2,
    input  logic          rx_enable,
    input  logic          addr_filter,
    input  logic          tx_tick,
    input  logic          rx_tick,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_bit9,
    input  logic          tx_done_clr,
    input  logic          rx_done_clr,
    input  logic          rxd,
    output logic          txd,
    output logic          tx_done,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_done
);
    logic      tx_t, rx_t, tx_stop, rx_acc, active, nine;
    tx_state_t tx_st;
    rx_state_t rx_st;

    assign active = (mode != MODE_OFF);
    assign nine   = mode[1];

    sp_rate_sel #(.FIXED_DIV(FIXED_DIV), .OVS(OVS)) u_rate (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rate_x2(rate_x2),
        .tx_tick_ext(tx_tick), .rx_tick_ext(rx_tick),
        .tx_tick(tx_t), .rx_tick(rx_t)
    );

    sp_tx_fsm #(.OVS(OVS), .DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(active), .nine(nine), .tick(tx_t),
        .wr(tx_wr), .data(tx_data), .bit9(tx_bit9), .txd(txd),
        .stop_enter(tx_stop), .state_o(tx_st)
    );

    sp_rx_fsm #(.OVS(OVS), .DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(active && rx_enable), .nine(nine),
        .tick(rx_t), .rxd_raw(rxd), .addr_filter(addr_filter), .busy(rx_done),
        .accept(rx_acc), .data_o(rx_data), .bit9_o(rx_bit9), .state_o(rx_st)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            if (tx_stop)          tx_done <= 1'b1;
            else if (tx_done_clr) tx_done <= 1'b0;
            if (rx_acc)           rx_done <= 1'b1;
            else if (rx_done_clr) rx_done <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_port_sva.sv
module serial_port_sva
    import serial_port_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          rx_enable,
    input logic          addr_filter,
    input logic          rx_done_clr,
    input logic          txd,
    input logic          tx_done,
    input logic          rx_done,
    input logic [DW-1:0] rx_data,
    input logic          rx_bit9,
    input tx_state_t     tx_st,
    input rx_state_t     rx_st
);
    // R5: flag rises together with the stop bit on the line
    a_r5_done_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (txd && tx_st == TX_STOP));

    // R5: start bit only follows the boundary wait
    a_r5_start_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(txd) && tx_st == TX_START) |-> $past(tx_st) == TX_WAIT);

    // R9: a full buffer holds its contents
    a_r9_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_done_clr) |=> ($stable(rx_data) && $stable(rx_bit9)));

    // R9: acceptance only at the stop-bit decision
    a_r9_rise_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(rx_st) == RX_STOP);

    // R10: filtered frames carry a high ninth bit
    a_r10_addr_ninth: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_done) && $past(addr_filter) && $past(mode[1])) |-> rx_bit9);

    // R6: receiver stays idle while disabled
    a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_st == RX_IDLE && !rx_enable) |=> rx_st == RX_IDLE);

    // R12: transmitter stays idle in the off mode
    a_r12_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && tx_st == TX_IDLE) |=> tx_st == TX_IDLE);
endmodule

bind serial_port_core serial_port_sva #(.DW(DW)) u_sva (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_enable(rx_enable),
    .addr_filter(addr_filter), .rx_done_clr(rx_done_clr), .txd(txd),
    .tx_done(tx_done), .rx_done(rx_done), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .tx_st(tx_st), .rx_st(rx_st)
);

// File: tb/serial_port_core_tb_top.sv
`timescale 1ns/1ps
module serial_port_core_tb_top;
    localparam int TXN = 3;
    localparam int RXN = 2;
    localparam int WD  = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b01;
    logic rate_x2 = 0, rx_enable = 0, addr_filter = 0;
    logic tx_tick = 0, rx_tick = 0, tx_wr = 0, tx_bit9 = 0;
    logic [7:0] tx_data = 0;
    logic tx_done_clr = 0, rx_done_clr = 0, rxd = 1;
    logic txd, tx_done, rx_bit9, rx_done;
    logic [7:0] rx_data;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    serial_port_core dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rate_x2(rate_x2),
        .rx_enable(rx_enable), .addr_filter(addr_filter), .tx_tick(tx_tick),
        .rx_tick(rx_tick), .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit9(tx_bit9),
        .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr), .rxd(rxd),
        .txd(txd), .tx_done(tx_done), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_done(rx_done)
    );

    initial begin
        int tc, rc;
        tc = 0; rc = 0;
        forever begin
            @(negedge clk);
            tc++; rc++;
            tx_tick = (tc % TXN == 0);
            rx_tick = (rc % RXN == 0);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] frame(input logic [7:0] d, input logic b9, input logic nine);
        logic [10:0] f;
        f = '1;
        f[0] = 1'b0;
        f[8:1] = d;
        if (nine) f[9] = b9;
        return f;
    endfunction

    function automatic int per_tx(input logic [1:0] m, input logic x2);
        return (m == 2'b10) ? (x2 ? 32 : 64) : 16 * TXN;
    endfunction

    function automatic int per_rx(input logic [1:0] m, input logic x2);
        return (m == 2'b10) ? (x2 ? 32 : 64) : 16 * RXN;
    endfunction

    task automatic clr_flags();
        @(negedge clk); tx_done_clr = 1; rx_done_clr = 1;
        @(negedge clk); tx_done_clr = 0; rx_done_clr = 0;
    endtask

    task automatic do_write(input logic [7:0] d, input logic b9);
        @(negedge clk); tx_data = d; tx_bit9 = b9; tx_wr = 1;
        @(negedge clk); tx_wr = 0;
    endtask

    task automatic capture_tx(input int P, input logic nine, output logic [10:0] bits,
                              output logic pre, output logic at_stop);
        int nb, t;
        nb = nine ? 11 : 10;
        t = 0;
        bits = '1; pre = 1'bx; at_stop = 1'bx;
        while (txd !== 1'b0 && t < 40 * P) begin @(negedge clk); t++; end
        repeat (P / 2) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < nb; i++) begin
            repeat (P) @(negedge clk);
            bits[i] = txd;
            if (i == nb - 2) pre = tx_done;
            if (i == nb - 1) at_stop = tx_done;
        end
        repeat (P) @(negedge clk);
    endtask

    task automatic send_rx(input int P, input logic [10:0] f, input int nb, input int gl);
        for (int i = 0; i < nb; i++) begin
            rxd = f[i];
            if (i == gl) begin
                repeat (34) @(negedge clk);
                rxd = ~f[i];
                repeat (2) @(negedge clk);
                rxd = f[i];
                repeat (P - 36) @(negedge clk);
            end else begin
                repeat (P) @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (P) @(negedge clk);
    endtask

    task automatic tx_case(input string tag, input logic [1:0] m, input logic x2,
                           input logic [7:0] d, input logic b9, input logic second);
        logic [10:0] got;
        logic pre, stp;
        int P;
        mode = m; rate_x2 = x2;
        P = per_tx(m, x2);
        clr_flags();
        do_write(d, b9);
        if (second) begin
            repeat (3) @(negedge clk);
            do_write(~d, ~b9);
        end
        capture_tx(P, m[1], got, pre, stp);
        chk({tag, " frame bits"}, {21'd0, got}, {21'd0, frame(d, b9, m[1])});
        chk({tag, " R5 flag low before stop"}, {31'd0, pre}, 32'd0);
        chk({tag, " R5 flag high at stop"}, {31'd0, stp}, 32'd1);
    endtask

    task automatic rx_case(input string tag, input logic [1:0] m, input logic x2,
                           input logic [10:0] f, input int gl, input logic clear,
                           input logic exp_done, input logic [7:0] exp_d, input logic exp_b9);
        mode = m; rate_x2 = x2;
        if (clear) clr_flags();
        send_rx(per_rx(m, x2), f, m[1] ? 11 : 10, gl);
        chk({tag, " rx_done"}, {31'd0, rx_done}, {31'd0, exp_done});
        chk({tag, " rx_data"}, {24'd0, rx_data}, {24'd0, exp_d});
        chk({tag, " rx_bit9"}, {31'd0, rx_bit9}, {31'd0, exp_b9});
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic b9, seen_low;
        logic [1:0] m;
        logic [7:0] last_d;
        logic last_b9;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        // R1: reset values
        chk("R1 txd", {31'd0, txd}, 32'd1);
        chk("R1 tx_done", {31'd0, tx_done}, 32'd0);
        chk("R1 rx_done", {31'd0, rx_done}, 32'd0);
        chk("R1 rx_data", {24'd0, rx_data}, 32'd0);
        chk("R1 rx_bit9", {31'd0, rx_bit9}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5: second write during a frame is ignored
        tx_case("R5 busy write", 2'b10, 1'b0, 8'hA5, 1'b1, 1'b1);
        // R3: fixed rate at both dividers
        tx_case("R3 fixed /64", 2'b10, 1'b0, 8'h3C, 1'b0, 1'b0);
        tx_case("R3 fixed /32", 2'b10, 1'b1, 8'hC3, 1'b1, 1'b0);
        // R2 and R4: random frames across the framings
        for (int k = 0; k < 6; k++) begin
            m = 2'((k % 3) + 1);
            d = 8'($urandom_range(0, 255));
            b9 = 1'($urandom_range(0, 1));
            tx_case(m == 2'b10 ? "R2 R3 tx random" : "R2 R4 tx random", m,
                    1'($urandom_range(0, 1)), d, b9, 1'b0);
        end

        // R12: mode 00 ignores writes
        mode = 2'b00;
        clr_flags();
        do_write(8'h00, 1'b0);
        seen_low = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd === 1'b0) seen_low = 1'b1;
        end
        chk("R12 txd stays idle", {31'd0, seen_low}, 32'd0);
        chk("R12 tx_done stays low", {31'd0, tx_done}, 32'd0);

        // R2 R4 R9: random receptions
        rx_enable = 1'b1;
        last_d = 8'h00; last_b9 = 1'b0;
        for (int k = 0; k < 6; k++) begin
            m = 2'((k % 3) + 1);
            d = 8'($urandom_range(0, 255));
            b9 = 1'($urandom_range(0, 1));
            rx_case(m == 2'b10 ? "R2 R3 R9 rx random" : "R2 R4 R9 rx random", m,
                    1'($urandom_range(0, 1)), frame(d, b9, m[1]), -1, 1'b1, 1'b1,
                    d, m[1] ? b9 : 1'b1);
            last_d = d;
            last_b9 = m[1] ? b9 : 1'b1;
        end

        // R9: full buffer drops the next frame
        rx_case("R9 full drop", 2'b10, 1'b0, frame(~last_d, ~last_b9, 1'b1), -1,
                1'b0, 1'b1, last_d, last_b9);
        // R11: clears
        clr_flags();
        chk("R11 rx_done cleared", {31'd0, rx_done}, 32'd0);
        chk("R11 tx_done cleared", {31'd0, tx_done}, 32'd0);
        // R9: bad stop bit
        rx_case("R9 bad stop", 2'b10, 1'b0, frame(8'h5A, 1'b1, 1'b1) & 11'h3FF, -1,
                1'b1, 1'b0, last_d, last_b9);
        // R12: off mode does not receive
        rx_case("R12 rx off", 2'b00, 1'b0, frame(8'h11, 1'b1, 1'b0), -1,
                1'b1, 1'b0, last_d, last_b9);
        // R6: receive disabled
        rx_enable = 1'b0;
        rx_case("R6 rx disabled", 2'b10, 1'b0, frame(8'h77, 1'b1, 1'b1), -1,
                1'b1, 1'b0, last_d, last_b9);
        rx_enable = 1'b1;
        // R7: single glitched sample
        rx_case("R7 glitch vote", 2'b10, 1'b0, frame(8'hF0, 1'b0, 1'b1), 3,
                1'b1, 1'b1, 8'hF0, 1'b0);
        // R8: false start
        mode = 2'b10; rate_x2 = 1'b0;
        clr_flags();
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (64 * 12) @(negedge clk);
        chk("R8 false start rx_done", {31'd0, rx_done}, 32'd0);
        chk("R8 false start rx_data", {24'd0, rx_data}, 32'hF0);
        // R10: address filter
        addr_filter = 1'b1;
        rx_case("R10 ninth low dropped", 2'b11, 1'b0, frame(8'h2B, 1'b0, 1'b1), -1,
                1'b1, 1'b0, 8'hF0, 1'b0);
        rx_case("R10 ninth high taken", 2'b11, 1'b0, frame(8'h2B, 1'b1, 1'b1), -1,
                1'b1, 1'b1, 8'h2B, 1'b1);
        rx_case("R10 no effect mode 01", 2'b01, 1'b0, frame(8'hD4, 1'b0, 1'b0), -1,
                1'b1, 1'b1, 8'hD4, 1'b1);
        addr_filter = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule